// File: doc/BRIEF.md
# Programmable Interval Timer Bank

This block holds a bank of identical down-counting timer channels driven by a shared tick enable, normally a 1 MHz strobe produced elsewhere. Each channel can fire once or keep firing at a fixed interval. It raises a level-sensitive, active-high interrupt line of its own on every expiry. Software programs a channel with a single 32-bit word that carries a run flag, a repeat flag and a 29-bit count. A second word, written separately, drops the pending interrupt.

Channels sit at a fixed 8-byte stride in a small register window. Each channel has a control/count word at byte offset 0 and an interrupt word at byte offset 4. The bus side is a plain single-cycle write strobe with a combinational read. The count uses an n+1 scheme, so software programs the desired interval minus one. For example, a value of 9999 with a 1 MHz tick gives a 100 Hz periodic interrupt.

Top module: `tick_interval_timer`

## Requirements
- R1: After reset every channel is stopped with a zero count, every irq line is low, and every register reads as zero.
- R2: The control word at channel offset 0 holds the run flag in bit 31, the repeat flag in bit 30 and the count in bits 28:0. Writing it loads the counter at once, even while the channel runs. A write in the same cycle as a tick takes priority over the tick.
- R3: While a channel is running, each cycle with tick high lowers its count by one. Cycles without tick, and stopped channels, leave the count unchanged.
- R4: A programmed count N expires on the (N+1)th tick after the write.
- R5: In one-shot mode (bit 30 low), expiry clears the run flag and leaves the count at zero.
- R6: In repeat mode (bit 30 high), expiry reloads the programmed count and keeps the run flag set, so expiries recur every N+1 ticks.
- R7: The irq line rises after an expiry and stays high until it is cleared, even if the channel is stopped or reprogrammed meanwhile.
- R8: Writing a word with bit 30 set to channel offset 4 clears that channel's pending interrupt. A write with bit 30 low has no effect. An expiry in the same cycle as a clear leaves the interrupt pending. Reading offset 4 returns the pending flag in bit 30 and zeros elsewhere.
- R9: Writing an all-zero control word stops the channel. The count then reads zero and does not move on later ticks.
- R10: Channel k occupies byte addresses 8k (control) and 8k+4 (interrupt). An access to one channel leaves every other channel untouched. Reads of a slot with no channel return zero, and writes to such a slot change nothing.
- R11: Reading offset 0 returns the run flag, the repeat flag and the remaining count, with bit 29 reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable strobe, one pulse per timebase period |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1 to 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| irq | output | NUM_CH | Per-channel level interrupt, active high |

## Verification
The bench aims at the edges of the n+1 scheme: a count of zero, the tick that lands exactly on zero, and the tick after it. A design off by one there would fire a tick early or late, or stall at zero. It collides a control write with a tick, and a clear with an expiry. A wrong priority would either skip the new load or lose an interrupt. It stops and reprograms channels while an interrupt is pending, which catches a line that is not sticky. It also writes and reads slots of other channels and empty slots, which exposes stride or decode errors that leak between channels.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int WORD_W  = 32;
  localparam int CNT_W   = 29;
  localparam int RUN_BIT = 31;
  localparam int REP_BIT = 30;
  localparam int ACK_BIT = 30;

  typedef logic [CNT_W-1:0] count_t;

  typedef struct packed {
    logic   run;
    logic   rep;
    count_t count;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.run   = w[RUN_BIT];
    c.rep   = w[REP_BIT];
    c.count = w[CNT_W-1:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_ctrl(input logic run, input logic rep,
                                                  input count_t count);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RUN_BIT] = run;
    w[REP_BIT] = rep;
    w[CNT_W-1:0] = count;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic pend);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ACK_BIT] = pend;
    return w;
  endfunction

  function automatic logic is_ack(input logic [WORD_W-1:0] w);
    return w[ACK_BIT];
  endfunction

  // Count after one tick, given that expiry has not happened.
  function automatic count_t step_down(input count_t c);
    return c - count_t'(1);
  endfunction

endpackage

// File: rtl/timer_decode.sv
module timer_decode #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic              ack_bit,
  output logic [NUM_CH-1:0] wr_ctrl,
  output logic [NUM_CH-1:0] wr_ack,
  output logic [NUM_CH-1:0] sel_hit,
  output logic              sel_off
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] slot;
  assign slot    = bus_addr[ADDR_W-1:3];
  assign sel_off = bus_addr[2];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_slot
    assign sel_hit[k] = (slot == IDX_W'(k));
    assign wr_ctrl[k] = bus_wr && sel_hit[k] && !sel_off;
    assign wr_ack[k]  = bus_wr && sel_hit[k] && sel_off && ack_bit;
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_ctrl,
  input  logic              wr_ack,
  input  logic [WORD_W-1:0] wdata,
  output logic              run,
  output logic              rep,
  output count_t            count,
  output count_t            reload,
  output logic              expire,
  output logic              pend
);
  ctrl_t  new_ctrl;
  logic   at_zero;

  assign new_ctrl = unpack_ctrl(wdata);
  assign at_zero  = (count == '0);
  // A control write in the same cycle overrides the tick.
  assign expire   = tick && run && at_zero && !wr_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      rep    <= 1'b0;
      count  <= '0;
      reload <= '0;
    end else if (wr_ctrl) begin
      run    <= new_ctrl.run;
      rep    <= new_ctrl.rep;
      count  <= new_ctrl.count;
      reload <= new_ctrl.count;
    end else if (tick && run) begin
      if (at_zero) begin
        if (rep) count <= reload;
        else     run   <= 1'b0;
      end else begin
        count <= step_down(count);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (expire) pend <= 1'b1;
    else if (wr_ack) pend <= 1'b0;
  end
endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer
  import timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0]              ch_wr_ctrl;
  logic [NUM_CH-1:0]              ch_ack;
  logic [NUM_CH-1:0]              ch_hit;
  logic                           sel_off;
  logic [NUM_CH-1:0]              ch_run;
  logic [NUM_CH-1:0]              ch_rep;
  logic [NUM_CH-1:0]              ch_expire;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_count;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_reload;

  timer_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .ack_bit (is_ack(bus_wdata)),
    .wr_ctrl (ch_wr_ctrl),
    .wr_ack  (ch_ack),
    .sel_hit (ch_hit),
    .sel_off (sel_off)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    timer_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .wr_ctrl(ch_wr_ctrl[k]),
      .wr_ack (ch_ack[k]),
      .wdata  (bus_wdata),
      .run    (ch_run[k]),
      .rep    (ch_rep[k]),
      .count  (ch_count[k]),
      .reload (ch_reload[k]),
      .expire (ch_expire[k]),
      .pend   (irq[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_hit[k]) begin
        bus_rdata = sel_off ? pack_status(irq[k])
                            : pack_ctrl(ch_run[k], ch_rep[k], ch_count[k]);
      end
    end
  end
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 29
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick,
  input logic [NUM_CH-1:0]            wr_ctrl,
  input logic [NUM_CH-1:0]            ack,
  input logic [NUM_CH-1:0]            expire,
  input logic [NUM_CH-1:0]            run,
  input logic [NUM_CH-1:0]            rep,
  input logic [NUM_CH-1:0][CNT_W-1:0] count,
  input logic [NUM_CH-1:0][CNT_W-1:0] reload,
  input logic [NUM_CH-1:0]            irq
);
  a_r10_one_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_ctrl));
  a_r10_one_ack_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      tick && run[k] && count[k] != '0 && !wr_ctrl[k] |=> count[k] == $past(count[k]) - 1'b1);
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !wr_ctrl[k] |=> $stable(count[k]) && $stable(run[k]));
    a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      expire[k] && !rep[k] |=> !run[k] && count[k] == '0);
    a_r6_repeat_reload: assert property (@(posedge clk) disable iff (!rst_n)
      expire[k] && rep[k] |=> run[k] && count[k] == $past(reload[k]));
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq[k] && !ack[k] |=> irq[k]);
    a_r8_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
      expire[k] |=> irq[k]);
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack[k] && !expire[k] |=> !irq[k]);
  end
endmodule

bind tick_interval_timer timer_checker #(.NUM_CH(NUM_CH), .CNT_W(timer_pkg::CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .wr_ctrl(ch_wr_ctrl),
  .ack    (ch_ack),
  .expire (ch_expire),
  .run    (ch_run),
  .rep    (ch_rep),
  .count  (ch_count),
  .reload (ch_reload),
  .irq    (irq)
);

// File: tb/tick_interval_timer_bench.sv
module tick_interval_timer_bench;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:2] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NUM_CH-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tick_interval_timer #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_tick_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [2:0]  ch;
    logic [31:0] word;
    logic [15:0] ticks;
    logic [31:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  // Channel, control word, ticks, expected offset-0 read, expected irq.
  localparam vec_t VECS [7] = '{
    '{3'd0, 32'h8000_0005, 16'd3,  32'h8000_0002, 1'b0},
    '{3'd0, 32'h8000_0005, 16'd5,  32'h8000_0000, 1'b0},
    '{3'd0, 32'h8000_0005, 16'd6,  32'h0000_0000, 1'b1},
    '{3'd1, 32'h8000_0000, 16'd1,  32'h0000_0000, 1'b1},
    '{3'd1, 32'h8000_0000, 16'd0,  32'h8000_0000, 1'b0},
    '{3'd0, 32'h8000_0009, 16'd20, 32'h0000_0000, 1'b1},
    '{3'd1, 32'hC000_0002, 16'd7,  32'hC000_0001, 1'b1}
  };

  function automatic logic [ADDR_W-1:2] waddr(input int ch, input int off);
    logic [ADDR_W-1:0] b;
    b = ADDR_W'(ch * 8 + off);
    return b[ADDR_W-1:2];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input int ch, input int off, input logic [31:0] d,
                           input logic with_tick);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = waddr(ch, off); bus_wdata = d; tick = with_tick;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic read_reg(input int ch, input int off, output logic [31:0] d);
    @(negedge clk);
    bus_addr = waddr(ch, off);
    #1 d = bus_rdata;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "irq after reset", 32'(irq), 32'h0);
    read_reg(0, 0, rd); check("R1", "ch0 ctrl after reset", rd, 32'h0);
    read_reg(1, 4, rd); check("R1", "ch1 status after reset", rd, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // Vector walk: R2 R3 R4 R5 R6 R11
    foreach (VECS[i]) begin
      write_reg(int'(VECS[i].ch), 4, 32'h4000_0000, 1'b0);
      write_reg(int'(VECS[i].ch), 0, VECS[i].word, 1'b0);
      if (VECS[i].ticks != 0) run_ticks(int'(VECS[i].ticks));
      read_reg(int'(VECS[i].ch), 0, rd);
      check("R4", $sformatf("vector %0d readback", i), rd, VECS[i].exp_rd);
      check("R5", $sformatf("vector %0d irq", i), 32'(irq[VECS[i].ch]), 32'(VECS[i].exp_irq));
    end

    // Stop ch1 (periodic from last vector), clear both.
    write_reg(1, 0, 32'h0, 1'b0);
    write_reg(1, 4, 32'h4000_0000, 1'b0);
    write_reg(0, 4, 32'h4000_0000, 1'b0);
    check("R8", "both irqs cleared", 32'(irq), 32'h0);

    // R6: periodic reload and 100 Hz spacing at 1 MHz tick
    write_reg(0, 0, 32'hC000_0003, 1'b0);
    run_ticks(4);
    read_reg(0, 0, rd); check("R6", "periodic reload", rd, 32'hC000_0003);
    check("R6", "periodic first expiry", 32'(irq[0]), 32'h1);
    write_reg(0, 4, 32'h4000_0000, 1'b0);
    run_ticks(3);
    check("R6", "no early second expiry", 32'(irq[0]), 32'h0);
    run_ticks(1);
    check("R6", "second expiry", 32'(irq[0]), 32'h1);
    write_reg(0, 4, 32'h4000_0000, 1'b0);
    write_reg(0, 0, 32'hC000_270F, 1'b0);
    run_ticks(9999);
    check("R4", "9999 ticks no expiry", 32'(irq[0]), 32'h0);
    run_ticks(1);
    check("R4", "10000th tick expiry", 32'(irq[0]), 32'h1);

    // R7 R9: stop with pending irq
    write_reg(0, 0, 32'h0, 1'b0);
    read_reg(0, 0, rd); check("R9", "stopped reads zero", rd, 32'h0);
    run_ticks(5);
    read_reg(0, 0, rd); check("R9", "stopped does not count", rd, 32'h0);
    check("R7", "irq held after stop", 32'(irq[0]), 32'h1);

    // R8: clear needs bit 30
    write_reg(0, 4, 32'hBFFF_FFFF, 1'b0);
    check("R8", "write without bit30 ignored", 32'(irq[0]), 32'h1);
    read_reg(0, 4, rd); check("R8", "status pending", rd, 32'h4000_0000);
    write_reg(0, 4, 32'h4000_0000, 1'b0);
    read_reg(0, 4, rd); check("R8", "status after clear", rd, 32'h0);

    // R2: reload on the fly, write beats tick
    write_reg(0, 0, 32'h8000_0007, 1'b0);
    run_ticks(2);
    read_reg(0, 0, rd); check("R3", "two ticks", rd, 32'h8000_0005);
    idle(5);
    read_reg(0, 0, rd); check("R3", "no tick no change", rd, 32'h8000_0005);
    write_reg(0, 0, 32'h8000_0002, 1'b0);
    read_reg(0, 0, rd); check("R2", "reload while running", rd, 32'h8000_0002);
    write_reg(0, 0, 32'hA000_0010, 1'b1);
    read_reg(0, 0, rd); check("R11", "write beats tick, bit29 zero", rd, 32'h8000_0010);

    // R3: disabled channel holds count
    write_reg(0, 0, 32'h0000_0004, 1'b0);
    run_ticks(3);
    read_reg(0, 0, rd); check("R3", "disabled holds", rd, 32'h0000_0004);
    check("R3", "disabled no irq", 32'(irq[0]), 32'h0);

    // R8: expiry and clear in same cycle, expiry wins
    write_reg(0, 0, 32'h8000_0001, 1'b0);
    run_ticks(1);
    write_reg(0, 4, 32'h4000_0000, 1'b1);
    check("R8", "expiry beats clear", 32'(irq[0]), 32'h1);
    write_reg(0, 4, 32'h4000_0000, 1'b0);

    // R10: channel isolation and empty slots
    write_reg(0, 0, 32'h8000_0020, 1'b0);
    write_reg(1, 0, 32'h8000_0003, 1'b0);
    read_reg(0, 0, rd); check("R10", "ch0 untouched by ch1 write", rd, 32'h8000_0020);
    run_ticks(4);
    check("R10", "ch1 expired alone", 32'(irq), 32'h2);
    write_reg(0, 4, 32'h4000_0000, 1'b0);
    check("R10", "ch0 clear leaves ch1", 32'(irq), 32'h2);
    write_reg(5, 0, 32'h8000_0001, 1'b0);
    write_reg(5, 4, 32'h4000_0000, 1'b0);
    read_reg(5, 0, rd); check("R10", "empty slot reads zero", rd, 32'h0);
    read_reg(0, 0, rd); check("R10", "empty slot write harmless", rd, 32'h8000_001C);
    check("R10", "empty slot clear harmless", 32'(irq), 32'h2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule